// File: doc/BRIEF.md
# Grouped Interrupt Cause and Vector Controller

This block collects interrupt causes from hardware into four cause groups, each split into two sub-blocks of 32 cause bits. Every sub-block has its own latched cause word, a cause-set port that software can use to inject a cause, a per-bit mask with a separate clear port, and a log-mask word kept for software. Each of the eight sub-blocks feeds one message-signalled interrupt vector. Vector `v` is fed by group `v>>1`, sub-block `v&1`.

A vector raises its message request while three things hold: it has a pending unmasked cause, neither the global vector mask nor its own control word masks it, and its moderation counter has run out. The global mask is changed through two write addresses: one sets bits and one clears them. When a requested message is acknowledged, the vector's counter reloads to its 8-bit interval shifted left by a shared 4-bit period, and then counts down once per clock. This limits the message rate without losing any cause.

All registers are reached over a simple 32-bit register bus. A write takes effect on the clock edge where it is strobed. Reads are combinational from the address.

Top module: `intc_grouped_vec`

## Requirements
- R1: A one-cycle pulse on `hw_evt` bit `(g*2+s)*32+b` latches bit `b` of the cause word of group `g`, sub-block `s`. That word is read at address `0x10000 | g<<12 | s<<6 | 0x00`. The bit stays set until software clears it.
- R2: Writing a value to the cause-set word (offset `0x08` inside the sub-block) latches the written bits exactly as hardware events would.
- R3: Writing ones to the cause word (offset `0x00`) clears the matching latched bits. A hardware event on the same bit in the same cycle wins, and the bit stays set.
- R4: Writing the mask word (offset `0x10`) replaces the mask. Writing mask-clear (offset `0x18`) clears the written mask bits. The log-mask word is at offset `0x38`. A cause reaches its vector only while its mask bit is 0.
- R5: A write to `0x10` ORs the low 8 data bits into the global vector mask. A write to `0x18` clears the written bits. Both addresses read back the mask. A vector whose global mask bit is 1 raises no request.
- R6: The control word of vector `v` is at `0x80C + 16*v`, with bit 0 meaningful. A value of 1 masks the vector and 0 unmasks it.
- R7: Vector `v` requests only for causes of group `v>>1`, sub-block `v&1`.
- R8: After the edge where `irq_ack[v]` and `irq_req[v]` are both high, the request stays low for exactly `interval[v] << period` clock edges, then rises again if it is still eligible.
- R9: The moderation control word at `0x28` keeps only bits 27:24 as the period. Writing bit 4 as 1 zeroes every moderation counter at once. Bit 4 reads back as 0.
- R10: The interval of vector `v` is at `0x400 + 8*v`. Only its low 8 bits are stored and read back.
- R11: A cause-region write whose group field (address bits 14:12) is above 3 changes no state.
- R12: After reset, no request is raised, the global mask reads 0, every cause mask reads `0xFFFFFFFF`, and every cause word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 17 | Register byte address; bit 16 selects the cause region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_evt | input | 256 | Hardware cause pulses, 32 bits per sub-block, sub-block index `g*2+s` |
| irq_req | output | 8 | Per-vector message request, a level |
| irq_ack | input | 8 | Per-vector acknowledge, honoured only while the request is high |

## Verification
A register write or a cause pulse is registered on the next rising edge. Its effect on `bus_rdata` and on `irq_req` is visible in the half cycle after that edge, because both are combinational from the registers. The bench therefore drives every input on the falling edge and compares one time unit later, after exactly one rising edge. The moderation check counts the rising edges between the acknowledge edge and the return of the request, and compares that count with the interval shifted by the period.

// File: rtl/intc_gv_pkg.sv
package intc_gv_pkg;
  localparam int NUM_GRP  = 4;
  localparam int NUM_SUB  = 2;
  localparam int CW       = 32;
  localparam int INTV_W   = 8;
  localparam int PER_W    = 4;
  localparam int ADDR_W   = 17;
  localparam int NUM_VEC  = NUM_GRP * NUM_SUB;
  localparam int CNT_W    = INTV_W + (1 << PER_W) - 1;

  // top-region offsets
  localparam int OFF_GSET  = 'h10;
  localparam int OFF_GCLR  = 'h18;
  localparam int OFF_MOD   = 'h28;
  localparam int OFF_INTV  = 'h400;
  localparam int STEP_INTV = 8;
  localparam int OFF_VCTL  = 'h80C;
  localparam int STEP_VCTL = 16;
  localparam int PER_LSB   = 24;
  localparam int TCLR_BIT  = 4;

  // cause sub-block register offsets
  localparam logic [5:0] R_CAUSE = 6'h00;
  localparam logic [5:0] R_CSET  = 6'h08;
  localparam logic [5:0] R_MASK  = 6'h10;
  localparam logic [5:0] R_MCLR  = 6'h18;
  localparam logic [5:0] R_LOG   = 6'h38;

  function automatic logic [CNT_W-1:0] mod_reload(input logic [INTV_W-1:0] intv,
                                                   input logic [PER_W-1:0] per);
    return CNT_W'(intv) << per;
  endfunction

  function automatic logic [31:0] next_cause(input logic [31:0] cur, input logic [31:0] clr,
                                             input logic [31:0] hw, input logic [31:0] sw);
    return (cur & ~clr) | hw | sw;
  endfunction
endpackage

// File: rtl/intc_cause_bank.sv
module intc_cause_bank
  import intc_gv_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] evt,
  input  logic          wr_clr,
  input  logic          wr_set,
  input  logic          wr_mask,
  input  logic          wr_mclr,
  input  logic          wr_log,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cause,
  output logic [CW-1:0] mask,
  output logic [CW-1:0] logm,
  output logic [CW-1:0] clr_bits,
  output logic          pend
);
  logic [CW-1:0] set_bits;

  assign clr_bits = wr_clr ? wdata : '0;
  assign set_bits = wr_set ? wdata : '0;
  assign pend     = |(cause & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '1;
      logm  <= '0;
    end else begin
      cause <= next_cause(cause, clr_bits, evt, set_bits);
      if (wr_mask)      mask <= wdata;
      else if (wr_mclr) mask <= mask & ~wdata;
      if (wr_log)       logm <= wdata;
    end
  end
endmodule

// File: rtl/intc_mod_timer.sv
module intc_mod_timer
  import intc_gv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_clr,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (tmr_clr) cnt <= '0;
    else if (load)    cnt <= reload_val;
    else if (busy)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/intc_grouped_vec.sv
module intc_grouped_vec
  import intc_gv_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NUM_VEC*CW-1:0] hw_evt,
  output logic [NUM_VEC-1:0]    irq_req,
  input  logic [NUM_VEC-1:0]    irq_ack
);
  localparam int GRP_LSB = 12;
  localparam int SUB_LSB = 6;

  // register state
  logic [NUM_VEC-1:0] gmask;
  logic [NUM_VEC-1:0] vctl;
  logic [INTV_W-1:0]  intv [NUM_VEC];
  logic [PER_W-1:0]   period;

  // named internal events, also used by the checker
  logic               tmr_clr;
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] busy;
  logic [NUM_VEC-1:0] s_clr, s_set, s_mask, s_mclr, s_log;
  logic [NUM_VEC*CW-1:0] cause_f, mask_f, logm_f, clr_f;

  // address fields
  logic        in_cause;
  logic [2:0]  a_grp;
  logic [5:0]  a_sub;
  logic [5:0]  a_reg;
  logic [NUM_VEC-1:0] sel_bank;

  assign in_cause = bus_addr[16] && !bus_addr[15];
  assign a_grp    = bus_addr[GRP_LSB +: 3];
  assign a_sub    = bus_addr[SUB_LSB +: 6];
  assign a_reg    = bus_addr[5:0];

  function automatic logic top_hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++)
      sel_bank[v] = in_cause && (int'(a_grp) == v / NUM_SUB) && (int'(a_sub) == v % NUM_SUB);
  end

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      s_clr[v]  = bus_wr && sel_bank[v] && (a_reg == R_CAUSE);
      s_set[v]  = bus_wr && sel_bank[v] && (a_reg == R_CSET);
      s_mask[v] = bus_wr && sel_bank[v] && (a_reg == R_MASK);
      s_mclr[v] = bus_wr && sel_bank[v] && (a_reg == R_MCLR);
      s_log[v]  = bus_wr && sel_bank[v] && (a_reg == R_LOG);
    end
  end

  assign tmr_clr = bus_wr && top_hit(bus_addr, OFF_MOD) && bus_wdata[TCLR_BIT];

  // top-region registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask  <= '0;
      vctl   <= '0;
      period <= '0;
      for (int v = 0; v < NUM_VEC; v++) intv[v] <= '0;
    end else if (bus_wr) begin
      if (top_hit(bus_addr, OFF_GSET)) gmask <= gmask | bus_wdata[NUM_VEC-1:0];
      if (top_hit(bus_addr, OFF_GCLR)) gmask <= gmask & ~bus_wdata[NUM_VEC-1:0];
      if (top_hit(bus_addr, OFF_MOD))  period <= bus_wdata[PER_LSB +: PER_W];
      for (int v = 0; v < NUM_VEC; v++) begin
        if (top_hit(bus_addr, OFF_INTV + STEP_INTV * v)) intv[v] <= bus_wdata[INTV_W-1:0];
        if (top_hit(bus_addr, OFF_VCTL + STEP_VCTL * v)) vctl[v] <= bus_wdata[0];
      end
    end
  end

  // per-vector cause bank and moderation timer
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    logic [CW-1:0] cause_w, mask_w, logm_w, clr_w;

    intc_cause_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (hw_evt[v*CW +: CW]),
      .wr_clr   (s_clr[v]),
      .wr_set   (s_set[v]),
      .wr_mask  (s_mask[v]),
      .wr_mclr  (s_mclr[v]),
      .wr_log   (s_log[v]),
      .wdata    (bus_wdata),
      .cause    (cause_w),
      .mask     (mask_w),
      .logm     (logm_w),
      .clr_bits (clr_w),
      .pend     (pend[v])
    );

    intc_mod_timer u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_clr    (tmr_clr),
      .load       (irq_ack[v] && irq_req[v]),
      .reload_val (mod_reload(intv[v], period)),
      .busy       (busy[v])
    );

    assign cause_f[v*CW +: CW] = cause_w;
    assign mask_f[v*CW +: CW]  = mask_w;
    assign logm_f[v*CW +: CW]  = logm_w;
    assign clr_f[v*CW +: CW]   = clr_w;
    assign irq_req[v] = pend[v] && !gmask[v] && !vctl[v] && !busy[v];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (top_hit(bus_addr, OFF_GSET) || top_hit(bus_addr, OFF_GCLR))
      bus_rdata = 32'(gmask);
    if (top_hit(bus_addr, OFF_MOD))
      bus_rdata = 32'(period) << PER_LSB;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (top_hit(bus_addr, OFF_INTV + STEP_INTV * v)) bus_rdata = 32'(intv[v]);
      if (top_hit(bus_addr, OFF_VCTL + STEP_VCTL * v)) bus_rdata = 32'(vctl[v]);
      if (sel_bank[v]) begin
        if (a_reg == R_CAUSE) bus_rdata = cause_f[v*CW +: CW];
        if (a_reg == R_MASK)  bus_rdata = mask_f[v*CW +: CW];
        if (a_reg == R_LOG)   bus_rdata = logm_f[v*CW +: CW];
      end
    end
  end
endmodule

// File: rtl/intc_grouped_vec_chk.sv
module intc_grouped_vec_chk
  import intc_gv_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_VEC-1:0]    irq_req,
  input logic [NUM_VEC-1:0]    gmask,
  input logic [NUM_VEC-1:0]    vctl,
  input logic [NUM_VEC-1:0]    pend,
  input logic [NUM_VEC-1:0]    busy,
  input logic [NUM_VEC*CW-1:0] hw_evt,
  input logic [NUM_VEC*CW-1:0] cause_f,
  input logic [NUM_VEC*CW-1:0] clr_f
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_a
    // R5 and R6: a requesting vector is masked by neither mask
    p_req_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[v] |-> (!gmask[v] && !vctl[v]));
    // R4: a request needs a pending unmasked cause
    p_req_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[v] |-> pend[v]);
    // R8: no request while the moderation counter runs
    p_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[v] |-> !busy[v]);
    // R1: latched causes persist unless cleared
    p_cause_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_f[v*CW +: CW] & ~clr_f[v*CW +: CW]) != '0 |=>
        (($past(cause_f[v*CW +: CW]) & ~$past(clr_f[v*CW +: CW])) & ~cause_f[v*CW +: CW]) == '0);
    // R3: a hardware event beats a same-cycle clear
    p_hw_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_evt[v*CW +: CW] != '0) |=>
        ((cause_f[v*CW +: CW] & $past(hw_evt[v*CW +: CW])) == $past(hw_evt[v*CW +: CW])));
  end
endmodule

bind intc_grouped_vec intc_grouped_vec_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_req (irq_req),
  .gmask   (gmask),
  .vctl    (vctl),
  .pend    (pend),
  .busy    (busy),
  .hw_evt  (hw_evt),
  .cause_f (cause_f),
  .clr_f   (clr_f)
);

// File: tb/intc_grouped_vec_tb.sv
module intc_grouped_vec_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [16:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] hw_evt = '0;
  logic [7:0]   irq_req;
  logic [7:0]   irq_ack = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_grouped_vec u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
    .irq_req(irq_req), .irq_ack(irq_ack)
  );

  // {write, addr, data or expected, requirement number}
  localparam int NT = 16;
  localparam logic [53:0] TBL [NT] = '{
    {1'b0, 17'h00010, 32'h0000_0000, 4'd12}, // R12 global mask reset
    {1'b1, 17'h00010, 32'h0000_0005, 4'd5},  // R5 set port
    {1'b1, 17'h00010, 32'h0000_0030, 4'd5},
    {1'b0, 17'h00018, 32'h0000_0035, 4'd5},
    {1'b1, 17'h00018, 32'h0000_0004, 4'd5},  // R5 clear port
    {1'b0, 17'h00010, 32'h0000_0031, 4'd5},
    {1'b1, 17'h00018, 32'h0000_00FF, 4'd5},
    {1'b0, 17'h00010, 32'h0000_0000, 4'd5},
    {1'b1, 17'h00428, 32'h0000_01AB, 4'd10}, // R10 interval width
    {1'b0, 17'h00428, 32'h0000_00AB, 4'd10},
    {1'b1, 17'h00028, 32'hFFFF_FFFF, 4'd9},  // R9 period field only
    {1'b0, 17'h00028, 32'h0F00_0000, 4'd9},
    {1'b1, 17'h00028, 32'h0000_0000, 4'd9},
    {1'b1, 17'h0087C, 32'h0000_0001, 4'd6},  // R6 vector 7 control
    {1'b0, 17'h0087C, 32'h0000_0001, 4'd6},
    {1'b1, 17'h0087C, 32'h0000_0000, 4'd6}
  };

  function automatic logic [16:0] caddr(int g, int s, int r);
    return 17'h10000 + 17'(g * 4096) + 17'(s * 64) + 17'(r);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [16:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(string tag, logic [16:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 req", 32'(irq_req), 32'h0);
    rd("R12 mask", caddr(2, 1, 'h10), 32'hFFFF_FFFF);
    rd("R12 cause", caddr(3, 0, 0), 32'h0);

    for (int i = 0; i < NT; i++) begin
      if (TBL[i][53]) wr(TBL[i][52:36], TBL[i][35:4]);
      else rd($sformatf("R%0d table %0d", TBL[i][3:0], i), TBL[i][52:36], TBL[i][35:4]);
    end

    // R1: hardware pulse on group 1 sub 1 bit 5
    @(negedge clk);
    hw_evt[3*32+5] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_evt = '0;
    step(); step();
    rd("R1 latched", caddr(1, 1, 0), 32'h20);
    // R7: unmask bit 5, only vector 3 requests
    wr(caddr(1, 1, 'h18), 32'h20);
    chk("R7 mapping", 32'(irq_req), 32'h08);
    // R3: write-one clear
    wr(caddr(1, 1, 0), 32'h20);
    rd("R3 clear", caddr(1, 1, 0), 32'h0);
    chk("R3 req gone", 32'(irq_req), 32'h0);
    // R3: hardware beats same-cycle clear
    @(negedge clk);
    hw_evt[3*32+5] = 1'b1;
    bus_addr = caddr(1, 1, 0); bus_wdata = 32'h20; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_evt = '0; bus_wr = 1'b0;
    rd("R3 priority", caddr(1, 1, 0), 32'h20);
    wr(caddr(1, 1, 0), 32'hFFFF_FFFF);
    wr(caddr(1, 1, 'h10), 32'hFFFF_FFFF);

    // R2: software set on group 0 sub 0 bit 2
    wr(caddr(0, 0, 8), 32'h4);
    rd("R2 set", caddr(0, 0, 0), 32'h4);
    chk("R4 masked", 32'(irq_req), 32'h0);
    wr(caddr(0, 0, 'h18), 32'h4);
    rd("R4 mask clear", caddr(0, 0, 'h10), 32'hFFFF_FFFB);
    chk("R4 unmasked", 32'(irq_req), 32'h01);
    wr(caddr(0, 0, 'h10), 32'hFFFF_FFFF);
    chk("R4 remask", 32'(irq_req), 32'h0);
    wr(caddr(0, 0, 'h10), 32'hFFFF_FFFB);
    wr(caddr(0, 0, 'h38), 32'h1234_5678);
    rd("R4 log mask", caddr(0, 0, 'h38), 32'h1234_5678);
    chk("R4 req back", 32'(irq_req), 32'h01);

    // R5 / R6 gating
    wr(17'h10, 32'h01);
    chk("R5 gmask", 32'(irq_req), 32'h0);
    wr(17'h18, 32'h01);
    chk("R5 gmask clr", 32'(irq_req), 32'h01);
    wr(17'h80C, 32'h1);
    chk("R6 vctl", 32'(irq_req), 32'h0);
    wr(17'h80C, 32'h0);
    chk("R6 vctl off", 32'(irq_req), 32'h01);

    // R8: interval 3, period 1 -> 6 edges of silence
    wr(17'h400, 32'h3);
    wr(17'h28, 32'h0100_0000);
    @(negedge clk);
    irq_ack = 8'h01;
    @(posedge clk);
    @(negedge clk);
    irq_ack = '0;
    #1;
    k = 0;
    while (!irq_req[0] && k < 100) begin
      step();
      k++;
    end
    chk("R8 holdoff", 32'(k), 32'd6);

    // R9: long holdoff cut short by the timer reset bit
    wr(17'h400, 32'hFF);
    wr(17'h28, 32'h0400_0000);
    @(negedge clk);
    irq_ack = 8'h01;
    @(posedge clk);
    @(negedge clk);
    irq_ack = '0;
    #1;
    step(); step();
    chk("R8 long holdoff", 32'(irq_req), 32'h0);
    wr(17'h28, 32'h0400_0010);
    chk("R9 timer reset", 32'(irq_req), 32'h01);
    rd("R9 readback", 17'h28, 32'h0400_0000);

    // R11: group field 4 is not an alias of group 0
    wr(17'h10000 + 17'h4000 + 17'h8, 32'h8000_0000);
    rd("R11 no alias", caddr(0, 0, 0), 32'h4);
    wr(17'h10000 + 17'h4000 + 17'h18, 32'hFFFF_FFFF);
    rd("R11 mask kept", caddr(0, 0, 'h10), 32'hFFFF_FFFB);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule